// File: doc/BRIEF.md
# I2C Interrupt Event Collector

This unit sits beside the serial engine of an I2C controller and turns its hardware event strobes into processor-visible state. Seven kinds of event arrive as one-cycle pulses on a single input vector: arbitration lost, no-acknowledge, register-access ready, receive ready, transmit ready, stop detected and addressed as slave. Each pulse sets a sticky flag. A mask register enables individual flags onto one interrupt line.

Software services the line by reading a vector register. Each read returns a 3-bit code for the most urgent pending event that is enabled, and clears that event's flag. An interrupt handler therefore reads the vector register repeatedly until it returns zero. Software can also clear flags in other ways: write-one-to-clear on two status bits, a read of the receive data location, or a write of the transmit data location. The status register also shows two live bus conditions, receive shift full and bus busy, which are never latched.

Top module: `i2c_evt_irq`

## Requirements
- R1: After reset all seven flags and the mask are 0, the interrupt output is low and the vector register reads 0.
- R2: A pulse on evtPulse bit i sets status bit i on the next clock edge, whatever the mask. The bit order is: arbitration lost 0, no-ack 1, access ready 2, receive ready 3, transmit ready 4, stop detect 5, addressed as slave 6.
- R3: The mask register at address 0 holds seven enable bits, in the same bit order as the status flags, and reads back what was written.
- R4: irq is high exactly when at least one flag is set whose mask bit is also set.
- R5: The vector register at address 2 reads the code of the lowest-numbered pending enabled event, or 0 when there is none. The codes are: arbitration lost 1, no-ack 2, access ready 3, receive ready 4, transmit ready 5, stop detect 6, addressed as slave 7.
- R6: A read of the vector register clears the flag whose code it returned. Repeated reads walk through all pending enabled events and then return 0.
- R7: A write to the status register at address 1 clears bit 2 (access ready) and bit 5 (stop detect) where the written data has a 1. A 1 written to any other flag bit has no effect.
- R8: Status bit 11 shows the rxFull input and bit 12 shows the busBusy input, live. A status write or a vector read does not change them.
- R9: A read of address 3 returns rxData and clears the receive-ready flag. A write to address 4 clears the transmit-ready flag. On the next cycle it also raises txLoad for one cycle, with txData holding the low bits of the written word.
- R10: When an event pulse and a clear of the same flag fall in the same cycle, the flag remains set.
- R11: A pending flag whose mask bit is 0 never appears in the vector, and a vector read leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects) |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, combinational from addr |
| evtPulse | input | 7 | One-cycle event pulses from the serial engine |
| rxFull | input | 1 | Live receive-shift-full condition |
| busBusy | input | 1 | Live bus-busy condition |
| rxData | input | RX_W | Received byte presented on a read of address 3 |
| txData | output | RX_W | Byte written to address 4 |
| txLoad | output | 1 | One-cycle pulse after a write to address 4 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default values: a 3-bit address, 16-bit data and 8-bit transfer data. These values place both live status bits, 11 and 12, inside the data word and give all five register locations plus unmapped addresses. A table of event and mask pairs checks the priority order and the masking for each pattern, including masked-only pending events. Directed sequences then cover a full drain through seven vector reads, the write-one-to-clear selectivity, the live bits, the data-location clears and the set-beats-clear collision.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NUM_EVT = 7;
  localparam int CODE_W  = $clog2(NUM_EVT + 1);

  localparam int EV_ARB  = 0;
  localparam int EV_NACK = 1;
  localparam int EV_ARDY = 2;
  localparam int EV_RXR  = 3;
  localparam int EV_TXR  = 4;
  localparam int EV_STOP = 5;
  localparam int EV_AAS  = 6;

  // flags that a status write may clear with a 1
  localparam logic [NUM_EVT-1:0] W1C_SET = 7'b0100100;

  typedef struct packed {
    logic wrMask;
    logic wrStat;
    logic rdVec;
    logic rdRx;
    logic wrTx;
  } evtStrobe_t;
endpackage

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio
  import i2c_evt_pkg::*;
(
  input  logic [NUM_EVT-1:0] pend,
  output logic [CODE_W-1:0]  code
);
  always_comb begin
    code = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
  import i2c_evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] A_MASK = 0,
  parameter logic [ADDR_W-1:0] A_STAT = 1,
  parameter logic [ADDR_W-1:0] A_VEC  = 2,
  parameter logic [ADDR_W-1:0] A_RX   = 3,
  parameter logic [ADDR_W-1:0] A_TX   = 4
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output evtStrobe_t        strb
);
  always_comb begin
    strb        = '0;
    strb.wrMask = wrEn && (addr == A_MASK);
    strb.wrStat = wrEn && (addr == A_STAT);
    strb.wrTx   = wrEn && (addr == A_TX);
    strb.rdVec  = rdEn && (addr == A_VEC);
    strb.rdRx   = rdEn && (addr == A_RX);
  end
endmodule

// File: rtl/i2c_evt_dpath.sv
module i2c_evt_dpath
  import i2c_evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int RX_W   = 8,
  parameter int FULL_BIT = 11,
  parameter int BUSY_BIT = 12,
  parameter logic [ADDR_W-1:0] A_MASK = 0,
  parameter logic [ADDR_W-1:0] A_STAT = 1,
  parameter logic [ADDR_W-1:0] A_VEC  = 2,
  parameter logic [ADDR_W-1:0] A_RX   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  evtStrobe_t         strb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               rxFull,
  input  logic               busBusy,
  input  logic [RX_W-1:0]    rxData,
  output logic [RX_W-1:0]    txData,
  output logic               txLoad,
  output logic               irq
);
  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] maskReg;
  logic [NUM_EVT-1:0] clrVec;
  logic [NUM_EVT-1:0] pend;
  logic [CODE_W-1:0]  vecCode;
  logic [DATA_W-1:0]  statWord;

  assign pend = flags & maskReg;

  i2c_evt_prio u_prio (.pend(pend), .code(vecCode));

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic byVec, byW1c, byData;
    assign byVec = strb.rdVec && (vecCode == CODE_W'(i + 1));
    if (W1C_SET[i]) begin : g_w1c
      assign byW1c = strb.wrStat && wrData[i];
    end else begin : g_now1c
      assign byW1c = 1'b0;
    end
    if (i == EV_RXR) begin : g_rx
      assign byData = strb.rdRx;
    end else if (i == EV_TXR) begin : g_tx
      assign byData = strb.wrTx;
    end else begin : g_nod
      assign byData = 1'b0;
    end
    assign clrVec[i] = byVec || byW1c || byData;

    always_ff @(posedge clk) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= evtPulse[i] | (flags[i] & ~clrVec[i]);
    end

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> flags[i]); // R10
    AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.rdVec && vecCode == CODE_W'(i + 1) && !evtPulse[i]) |=> !flags[i]); // R6
    AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[i]) |-> $past(strb.rdVec || strb.wrStat || strb.rdRx || strb.wrTx)); // R7
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      txData  <= '0;
      txLoad  <= 1'b0;
    end else begin
      if (strb.wrMask) maskReg <= wrData[NUM_EVT-1:0];
      txLoad <= strb.wrTx;
      if (strb.wrTx) txData <= wrData[RX_W-1:0];
    end
  end

  assign irq = |pend;

  always_comb begin
    statWord           = '0;
    statWord[NUM_EVT-1:0] = flags;
    statWord[FULL_BIT] = rxFull;
    statWord[BUSY_BIT] = busBusy;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_MASK: rdData[NUM_EVT-1:0] = maskReg;
      A_STAT: rdData = statWord;
      A_VEC:  rdData[CODE_W-1:0] = vecCode;
      A_RX:   rdData[RX_W-1:0] = rxData;
      default: rdData = '0;
    endcase
  end

  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rstN)
    irq == (vecCode != '0)); // R4
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    (vecCode != '0) |-> (flags[vecCode - 1'b1] &&
      ((pend & ((NUM_EVT'(1) << (vecCode - 1'b1)) - NUM_EVT'(1))) == '0))); // R5
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTx |=> (txLoad && txData == $past(wrData[RX_W-1:0]))); // R9
endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
  import i2c_evt_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16,
  parameter int RX_W     = 8,
  parameter int FULL_BIT = 11,
  parameter int BUSY_BIT = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               rxFull,
  input  logic               busBusy,
  input  logic [RX_W-1:0]    rxData,
  output logic [RX_W-1:0]    txData,
  output logic               txLoad,
  output logic               irq
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(4);

  evtStrobe_t strb;

  i2c_evt_ctrl #(
    .ADDR_W(ADDR_W), .A_MASK(A_MASK), .A_STAT(A_STAT),
    .A_VEC(A_VEC), .A_RX(A_RX), .A_TX(A_TX)
  ) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  i2c_evt_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RX_W(RX_W),
    .FULL_BIT(FULL_BIT), .BUSY_BIT(BUSY_BIT),
    .A_MASK(A_MASK), .A_STAT(A_STAT), .A_VEC(A_VEC), .A_RX(A_RX)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtPulse(evtPulse),
    .rxFull(rxFull), .busBusy(busBusy), .rxData(rxData),
    .txData(txData), .txLoad(txLoad), .irq(irq)
  );
endmodule

// File: tb/sim_i2c_evt_irq.sv
module sim_i2c_evt_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [6:0]  evtPulse = '0;
  logic        rxFull = 1'b0, busBusy = 1'b0;
  logic [7:0]  rxData = 8'h3C;
  logic [7:0]  txData;
  logic        txLoad, irq;

  int nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  i2c_evt_irq u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtPulse(evtPulse),
    .rxFull(rxFull), .busBusy(busBusy), .rxData(rxData),
    .txData(txData), .txLoad(txLoad), .irq(irq)
  );

  // {events, mask, expected code, expected irq}
  localparam int NROW = 8;
  localparam logic [17:0] TBL [NROW] = '{
    {7'h01, 7'h01, 3'd1, 1'b1},
    {7'h06, 7'h7F, 3'd2, 1'b1},
    {7'h40, 7'h40, 3'd7, 1'b1},
    {7'h40, 7'h3F, 3'd0, 1'b0},
    {7'h30, 7'h20, 3'd6, 1'b1},
    {7'h7F, 7'h78, 3'd4, 1'b1},
    {7'h0C, 7'h08, 3'd4, 1'b1},
    {7'h00, 7'h7F, 3'd0, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evtPulse = e;
    @(negedge clk); evtPulse = '0;
  endtask

  task automatic drain();
    logic [15:0] d;
    busWrite(3'd0, 16'h007F);
    for (int k = 0; k < 8; k++) busRead(3'd2, d);
  endtask

  initial begin
    #(4 * 200000);
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [6:0] e, m, left;
    logic [2:0] c;
    logic q;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", {15'd0, irq}, 16'd0);
    busRead(3'd1, d); check("R1 status", d, 16'h0000);
    busRead(3'd0, d); check("R1 mask", d, 16'h0000);
    busRead(3'd2, d); check("R1 vector", d, 16'h0000);

    // table walk: R2 R4 R5 R6 R11
    for (int r = 0; r < NROW; r++) begin
      {e, m, c, q} = TBL[r];
      busWrite(3'd0, {9'd0, m});
      pulse(e);
      busRead(3'd1, d); check("R2 status latch", d, {9'd0, e});
      check("R4 irq", {15'd0, irq}, {15'd0, q});
      busRead(3'd2, d); check("R5 vector code", d, {13'd0, c});
      left = (c == 0) ? e : (e & ~(7'd1 << (c - 1)));
      busRead(3'd1, d); check("R6/R11 after vector read", d, {9'd0, left});
      drain();
      busRead(3'd1, d); check("R6 drained", d, 16'h0000);
    end

    // R3 mask readback
    busWrite(3'd0, 16'hFF55);
    busRead(3'd0, d); check("R3 mask readback", d, 16'h0055);

    // R6 full drain in order
    busWrite(3'd0, 16'h007F);
    pulse(7'h7F);
    for (int k = 1; k <= 8; k++) begin
      busRead(3'd2, d); check("R6 drain order", d, (k == 8) ? 16'd0 : 16'(k));
    end
    check("R4 irq low after drain", {15'd0, irq}, 16'd0);

    // R7 write-one-to-clear selectivity
    pulse(7'h7F);
    busWrite(3'd1, 16'h007F);
    busRead(3'd1, d); check("R7 w1c bits 2,5 only", d, 16'h005B);
    drain();

    // R8 live bits
    rxFull = 1'b1; busBusy = 1'b1;
    @(negedge clk);
    busRead(3'd1, d); check("R8 live bits set", d, 16'h1800);
    busWrite(3'd1, 16'h1800);
    busRead(3'd2, d);
    busRead(3'd1, d); check("R8 live bits kept", d, 16'h1800);
    rxFull = 1'b0;
    busRead(3'd1, d); check("R8 live follows input", d, 16'h1000);
    busBusy = 1'b0;

    // R9 receive read clears receive-ready
    pulse(7'h08);
    busRead(3'd3, d); check("R9 rx data", d, 16'h003C);
    busRead(3'd1, d); check("R9 rx flag cleared", d, 16'h0000);

    // R9 transmit write clears transmit-ready and pulses txLoad
    pulse(7'h10);
    @(negedge clk); wrEn = 1'b1; addr = 3'd4; wrData = 16'h12A5;
    @(negedge clk); wrEn = 1'b0;
    check("R9 txLoad", {15'd0, txLoad}, 16'd1);
    check("R9 txData", {8'd0, txData}, 16'h00A5);
    @(negedge clk);
    check("R9 txLoad single", {15'd0, txLoad}, 16'd0);
    busRead(3'd1, d); check("R9 tx flag cleared", d, 16'h0000);

    // R10 set beats clear: status write and vector read
    @(negedge clk); evtPulse = 7'h04; wrEn = 1'b1; addr = 3'd1; wrData = 16'h0004;
    @(negedge clk); evtPulse = '0; wrEn = 1'b0;
    busRead(3'd1, d); check("R10 w1c collision", d, 16'h0004);
    busWrite(3'd0, 16'h0004);
    @(negedge clk); evtPulse = 7'h04; rdEn = 1'b1; addr = 3'd2;
    @(negedge clk); evtPulse = '0; rdEn = 1'b0;
    busRead(3'd1, d); check("R10 vector collision", d, 16'h0004);

    // R11 masked flag invisible to vector
    busWrite(3'd0, 16'h0000);
    busRead(3'd2, d); check("R11 masked vector", d, 16'h0000);
    busRead(3'd1, d); check("R11 masked kept", d, 16'h0004);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule